// File: doc/BRIEF.md
# Idle and Power-Down Controller

This block sequences the low-power states of a small microcontroller core. Software writes a control register holding an idle request bit, a power-down request bit and a sticky power-on flag. From these bits the block derives a CPU clock enable, a peripheral clock enable, the levels of the address-latch and program-store strobes while the core is halted, and the float and address controls for the two multiplexed bus ports when code runs from external program memory.

Idle halts only the CPU clock. Peripherals stay clocked, so an interrupt can arrive, and any interrupt returns the core to run. Power-down stops both clock domains and, in the default build, is left only through a warm hardware reset or a power-on event. The power-on flag lets boot code tell a cold start from a warm restart. Only a power-up event sets it, and only a software write of 0 clears it.

The block resets asynchronously and releases reset through a local two-stage synchronizer. All state changes take effect on the rising clock edge that samples the stimulus.

Top module: `pwr_mgmt_ctrl`

## Requirements
- R1: While `rst_ni` is low, the idle and power-down bits are 0, the power-on flag is 1, `rd_data_o` reads 8'h10, and both clock enables are 1.
- R2: A write in run state with bit 0 = 1 and bit 1 = 0 enters idle at the sampling edge. `cpu_clk_en_o` then reads 0 and `per_clk_en_o` reads 1.
- R3: A write in run state with bit 1 = 1 enters power-down at the sampling edge, and both clock enables read 0. Power-down wins when bits 0 and 1 are written together.
- R4: `irq_i` high in idle clears the idle bit and returns to run at the sampling edge. In run state `irq_i` has no effect.
- R5: In power-down `irq_i` has no effect (default `PD_IRQ_WAKE` = 0).
- R6: `ext_rst_i` clears the idle and power-down bits and leaves the power-on flag unchanged. It outranks `irq_i` and writes.
- R7: `por_evt_i` clears the idle and power-down bits and sets the power-on flag. It outranks all other inputs.
- R8: A write in run state with bit 4 = 0 clears the power-on flag. A write with bit 4 = 1 never sets it.
- R9: Register writes are ignored while in idle or power-down.
- R10: Readback layout: bit 0 is idle, bit 1 is power-down, bit 4 is the power-on flag. All other bits read 0 regardless of what was written.
- R11: `ale_o` and `psen_o` follow `ale_i` and `psen_i` in run state. Both are 1 in idle and 0 in power-down.
- R12: `p0_float_o` equals `ext_prog_i` in idle or power-down and is 0 in run. `p2_addr_o` equals `ext_prog_i` in idle only and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| por_evt_i | input | 1 | Synchronous power-up event, sets the flag |
| ext_rst_i | input | 1 | Synchronous warm hardware reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | DW | Control register write data |
| irq_i | input | 1 | Interrupt request from the interrupt controller |
| ale_i | input | 1 | Address-latch strobe from the core in run state |
| psen_i | input | 1 | Program-store strobe from the core in run state |
| ext_prog_i | input | 1 | Core executes from external program memory |
| rd_data_o | output | DW | Control register readback |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| ale_o | output | 1 | Address-latch strobe to the pin |
| psen_o | output | 1 | Program-store strobe to the pin |
| p0_float_o | output | 1 | Tri-state request for the low bus port |
| p2_addr_o | output | 1 | High bus port drives address (1) or port data (0) |
| mode_o | output | 2 | 0 run, 1 idle, 2 power-down |

## Verification
Every state change lands on the rising edge that samples the stimulus. The register bits, the readback and the registered clock enables therefore show the new value one edge after the inputs are driven, and the strobe and port controls follow at once from that state. The bench drives inputs on the falling edge, advances its model at the next rising edge, and compares all outputs at the falling edge after that. After `rst_ni` rises, stimulus is held off for three edges so that the two-stage reset release has finished.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pm_mode_e;

  typedef struct packed {
    logic pof;
    logic pd;
    logic idle;
  } pm_state_t;

  function automatic pm_mode_e pm_mode_of(input logic idle, input logic pd);
    if (pd)        return PM_DOWN;
    else if (idle) return PM_IDLE;
    else           return PM_RUN;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  generate
    if (STAGES <= 1) begin : g_single
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= 1'b1;
      end
      assign rst_no = sync_q;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
      assign rst_no = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_mode_pkg::*;
#(
  parameter int DW          = 8,
  parameter int IDLE_POS    = 0,
  parameter int PD_POS      = 1,
  parameter int POF_POS     = 4,
  parameter bit PD_IRQ_WAKE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_evt_i,
  input  logic          ext_rst_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          irq_i,
  output pm_state_t     st_q_o,
  output pm_state_t     st_d_o,
  output logic [DW-1:0] rd_data_o
);

  pm_state_t st_q;
  pm_state_t st_d;
  logic      low_pwr;
  logic      wake_ok;
  logic      st_upd;

  assign low_pwr = st_q.idle | st_q.pd;

  // Which low-power states an interrupt may leave
  generate
    if (PD_IRQ_WAKE) begin : g_wake_all
      assign wake_ok = 1'b1;
    end else begin : g_wake_idle
      assign wake_ok = ~st_q.pd;
    end
  endgenerate

  // Next state: power-up event, then warm reset, then wake, then write
  always_comb begin
    st_d = st_q;
    if (por_evt_i) begin
      st_d.pof  = 1'b1;
      st_d.pd   = 1'b0;
      st_d.idle = 1'b0;
    end else if (ext_rst_i) begin
      st_d.pd   = 1'b0;
      st_d.idle = 1'b0;
    end else if (low_pwr) begin
      if (irq_i && wake_ok) begin
        st_d.idle = 1'b0;
        st_d.pd   = 1'b0;
      end
    end else if (wr_en_i) begin
      st_d.idle = wr_data_i[IDLE_POS];
      st_d.pd   = wr_data_i[PD_POS];
      st_d.pof  = st_q.pof & wr_data_i[POF_POS];
    end
  end

  assign st_upd = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q.pof  <= 1'b1;
      st_q.pd   <= 1'b0;
      st_q.idle <= 1'b0;
    end else if (st_upd) begin
      st_q <= st_d;
    end
  end

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[IDLE_POS] = st_q.idle;
    rd_data_o[PD_POS]   = st_q.pd;
    rd_data_o[POF_POS]  = st_q.pof;
  end

  assign st_q_o = st_q;
  assign st_d_o = st_d;

endmodule

// File: rtl/pwr_gate_out.sv
module pwr_gate_out
  import pwr_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idle_q_i,
  input  logic       pd_q_i,
  input  logic       idle_d_i,
  input  logic       pd_d_i,
  input  logic       ale_i,
  input  logic       psen_i,
  input  logic       ext_prog_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       ale_o,
  output logic       psen_o,
  output logic       p0_float_o,
  output logic       p2_addr_o,
  output logic [1:0] mode_o
);

  logic     cpu_en_d, per_en_d;
  logic     cpu_en_q, per_en_q;
  logic     en_upd;
  pm_mode_e mode;

  // Enables registered from next state: glitch-free, same edge as the state
  always_comb begin
    cpu_en_d = ~(idle_d_i | pd_d_i);
    per_en_d = ~pd_d_i;
  end

  assign en_upd = (cpu_en_d != cpu_en_q) | (per_en_d != per_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_en_q <= 1'b1;
      per_en_q <= 1'b1;
    end else if (en_upd) begin
      cpu_en_q <= cpu_en_d;
      per_en_q <= per_en_d;
    end
  end

  assign mode = pm_mode_of(idle_q_i, pd_q_i);

  always_comb begin
    ale_o      = ale_i;
    psen_o     = psen_i;
    p0_float_o = 1'b0;
    p2_addr_o  = 1'b0;
    unique case (mode)
      PM_IDLE: begin
        ale_o      = 1'b1;
        psen_o     = 1'b1;
        p0_float_o = ext_prog_i;
        p2_addr_o  = ext_prog_i;
      end
      PM_DOWN: begin
        ale_o      = 1'b0;
        psen_o     = 1'b0;
        p0_float_o = ext_prog_i;
      end
      default: ;
    endcase
  end

  assign cpu_clk_en_o = cpu_en_q;
  assign per_clk_en_o = per_en_q;
  assign mode_o       = mode;

endmodule

// File: rtl/pwr_mgmt_ctrl.sv
module pwr_mgmt_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int DW          = 8,
  parameter int IDLE_POS    = 0,
  parameter int PD_POS      = 1,
  parameter int POF_POS     = 4,
  parameter bit PD_IRQ_WAKE = 1'b0,
  parameter int RST_STAGES  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_evt_i,
  input  logic          ext_rst_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          irq_i,
  input  logic          ale_i,
  input  logic          psen_i,
  input  logic          ext_prog_i,
  output logic [DW-1:0] rd_data_o,
  output logic          cpu_clk_en_o,
  output logic          per_clk_en_o,
  output logic          ale_o,
  output logic          psen_o,
  output logic          p0_float_o,
  output logic          p2_addr_o,
  output logic [1:0]    mode_o
);

  logic      rst_sync_n;
  pm_state_t st_q, st_d;

  pwr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  pwr_ctrl_reg #(
    .DW(DW), .IDLE_POS(IDLE_POS), .PD_POS(PD_POS), .POF_POS(POF_POS),
    .PD_IRQ_WAKE(PD_IRQ_WAKE)
  ) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .por_evt_i (por_evt_i),
    .ext_rst_i (ext_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .irq_i     (irq_i),
    .st_q_o    (st_q),
    .st_d_o    (st_d),
    .rd_data_o (rd_data_o)
  );

  pwr_gate_out u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .idle_q_i     (st_q.idle),
    .pd_q_i       (st_q.pd),
    .idle_d_i     (st_d.idle),
    .pd_d_i       (st_d.pd),
    .ale_i        (ale_i),
    .psen_i       (psen_i),
    .ext_prog_i   (ext_prog_i),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .ale_o        (ale_o),
    .psen_o       (psen_o),
    .p0_float_o   (p0_float_o),
    .p2_addr_o    (p2_addr_o),
    .mode_o       (mode_o)
  );

endmodule

// File: rtl/pwr_mgmt_ctrl_chk.sv
module pwr_mgmt_ctrl_chk #(
  parameter int DW          = 8,
  parameter int IDLE_POS    = 0,
  parameter int PD_POS      = 1,
  parameter int POF_POS     = 4,
  parameter bit PD_IRQ_WAKE = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          por_evt_i,
  input logic          ext_rst_i,
  input logic          irq_i,
  input logic [DW-1:0] rd_data_o,
  input logic          cpu_clk_en_o,
  input logic          per_clk_en_o,
  input logic          ale_o,
  input logic          psen_o
);

  localparam logic [DW-1:0] USED_MASK =
    (DW'(1) << IDLE_POS) | (DW'(1) << PD_POS) | (DW'(1) << POF_POS);

  logic in_idle, in_pd, pof;
  assign in_idle = rd_data_o[IDLE_POS] & ~rd_data_o[PD_POS];
  assign in_pd   = rd_data_o[PD_POS];
  assign pof     = rd_data_o[POF_POS];

  AST_IDLE_GATES_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_idle |-> (!cpu_clk_en_o && per_clk_en_o)); // R2

  AST_PD_STOPS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_pd |-> (!cpu_clk_en_o && !per_clk_en_o && !ale_o && !psen_o)); // R3

  AST_IRQ_WAKES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idle && irq_i) |=> cpu_clk_en_o); // R4

  AST_PD_HOLDS_ON_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!PD_IRQ_WAKE && in_pd && !ext_rst_i && !por_evt_i) |=> rd_data_o[PD_POS]); // R5

  AST_WARM_RST_KEEPS_POF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_rst_i && !por_evt_i) |=> (pof == $past(pof) && !rd_data_o[IDLE_POS] && !rd_data_o[PD_POS])); // R6

  AST_POR_SETS_POF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_evt_i |=> (pof && cpu_clk_en_o && per_clk_en_o)); // R7

  AST_POF_NEVER_SET_BY_SW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pof && !por_evt_i) |=> !pof); // R8

  AST_LP_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((in_idle || in_pd) && !irq_i && !ext_rst_i && !por_evt_i) |=> $stable(rd_data_o)); // R9

  AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~USED_MASK) == '0); // R10

endmodule

bind pwr_mgmt_ctrl pwr_mgmt_ctrl_chk #(
  .DW(DW), .IDLE_POS(IDLE_POS), .PD_POS(PD_POS), .POF_POS(POF_POS),
  .PD_IRQ_WAKE(PD_IRQ_WAKE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_evt_i    (por_evt_i),
  .ext_rst_i    (ext_rst_i),
  .irq_i        (irq_i),
  .rd_data_o    (rd_data_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .ale_o        (ale_o),
  .psen_o       (psen_o)
);

// File: tb/pwr_mgmt_ctrl_test.sv
module pwr_mgmt_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       por_evt, ext_rst, wr_en, irq, ale_in, psen_in, ext_prog;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       cpu_en, per_en, ale_out, psen_out, p0_float, p2_addr;
  logic [1:0] mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Bench model state
  logic m_idle, m_pd, m_pof;

  always #10 clk = ~clk; // 50 MHz

  pwr_mgmt_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .por_evt_i(por_evt), .ext_rst_i(ext_rst),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .irq_i(irq), .ale_i(ale_in),
    .psen_i(psen_in), .ext_prog_i(ext_prog), .rd_data_o(rd_data),
    .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en), .ale_o(ale_out),
    .psen_o(psen_out), .p0_float_o(p0_float), .p2_addr_o(p2_addr), .mode_o(mode)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return {3'b000, m_pof, 2'b00, m_pd, m_idle};
  endfunction

  // Model step, following R6..R9 priorities
  task automatic model_step(input logic w, input logic [7:0] d, input logic q,
                            input logic xr, input logic pe);
    if (pe) begin
      m_pof = 1'b1; m_pd = 1'b0; m_idle = 1'b0;
    end else if (xr) begin
      m_pd = 1'b0; m_idle = 1'b0;
    end else if (m_idle || m_pd) begin
      if (q && !m_pd) m_idle = 1'b0;
    end else if (w) begin
      m_idle = d[0]; m_pd = d[1]; m_pof = m_pof & d[4];
    end
  endtask

  task automatic compare(input string tag);
    logic lp;
    lp = m_idle | m_pd;
    chk({tag, " R10 readback"}, rd_data, exp_rd());
    chk({tag, " R2 cpu_clk_en"}, {7'd0, cpu_en}, {7'd0, ~lp});
    chk({tag, " R3 per_clk_en"}, {7'd0, per_en}, {7'd0, ~m_pd});
    chk({tag, " R11 ale"}, {7'd0, ale_out},
        {7'd0, m_pd ? 1'b0 : (m_idle ? 1'b1 : ale_in)});
    chk({tag, " R11 psen"}, {7'd0, psen_out},
        {7'd0, m_pd ? 1'b0 : (m_idle ? 1'b1 : psen_in)});
    chk({tag, " R12 p0_float"}, {7'd0, p0_float}, {7'd0, ext_prog & lp});
    chk({tag, " R12 p2_addr"}, {7'd0, p2_addr}, {7'd0, ext_prog & m_idle & ~m_pd});
  endtask

  // Called at a falling edge: drive, let the rising edge sample, compare
  task automatic cyc(input string tag, input logic w, input logic [7:0] d,
                     input logic q, input logic xr, input logic pe);
    wr_en = w; wr_data = d; irq = q; ext_rst = xr; por_evt = pe;
    ale_in   = 1'($urandom_range(1));
    psen_in  = 1'($urandom_range(1));
    ext_prog = 1'($urandom_range(1));
    @(posedge clk);
    model_step(w, d, q, xr, pe);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 1'b0; por_evt = 0; ext_rst = 0; wr_en = 0; wr_data = '0; irq = 0;
    ale_in = 1; psen_in = 0; ext_prog = 1;
    m_idle = 0; m_pd = 0; m_pof = 1;
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk("R1 rd_data", rd_data, 8'h10);
    chk("R1 clk enables", {6'd0, cpu_en, per_en}, 8'h03);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after release");

    cyc("R8 clear pof", 1, 8'h00, 0, 0, 0);
    cyc("R8 write 1 no set", 1, 8'h10, 0, 0, 0);
    cyc("R7 por sets pof", 0, 8'h00, 0, 0, 1);
    cyc("R10 reserved ignored", 1, 8'hFC, 0, 0, 0);
    cyc("R4 irq in run", 0, 8'h00, 1, 0, 0);
    cyc("R2 enter idle", 1, 8'h11, 0, 0, 0);
    cyc("R9 write in idle", 1, 8'h02, 0, 0, 0);
    cyc("R4 irq wakes", 0, 8'h00, 1, 0, 0);
    cyc("R3 both bits to pd", 1, 8'h13, 0, 0, 0);
    cyc("R5 irq in pd", 0, 8'h00, 1, 0, 0);
    cyc("R9 write in pd", 1, 8'h00, 0, 0, 0);
    cyc("R6 warm reset from pd", 0, 8'h00, 0, 1, 0);
    cyc("R8 clear pof again", 1, 8'h00, 0, 0, 0);
    cyc("R2 idle again", 1, 8'h01, 0, 0, 0);
    cyc("R6 reset over irq", 0, 8'h00, 1, 1, 0);
    cyc("R3 pd only", 1, 8'h02, 0, 0, 0);
    cyc("R7 por over reset", 1, 8'h01, 1, 1, 1);

    for (int i = 0; i < 3000; i++) begin
      logic w, q, xr, pe;
      logic [7:0] d;
      w  = ($urandom_range(99) < 35);
      d  = 8'($urandom);
      q  = ($urandom_range(99) < 15);
      xr = ($urandom_range(99) < 3);
      pe = ($urandom_range(199) < 2);
      cyc("RND", w, d, q, xr, pe);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule